// File: doc/BRIEF.md
# Serial Register Access Port for a Trace Buffer

This block gives a debug host serial access to a small bank of 32-bit trace-buffer control registers through a 40-bit shift frame. The host pulses `capture_i` once, shifts 40 bits in on `tdi_i` with `shift_i` while the previous result comes out on `tdo_o`, then pulses `update_i`. On update, the block latches the frame and does one of two things: it writes the data field into the addressed register, or it reads that register into a result holder. The held result goes into the data field at the next capture, so the data for a read comes back one scan later.

Nine addresses are decoded. Four are read-only constants or live inputs: identification, RAM depth, RAM width and status. One is a streaming port onto the trace RAM. Four hold state that the rest of the trace logic uses: read pointer, write pointer, trigger count and control. A read of the RAM data address returns the word at the read pointer and advances the pointer. To read N trace words, the host issues N RAM data reads and then finishes with a read of address 0, which has no side effect.

Top module: `sap_scan_port`

## Requirements
- R1: The frame is 40 bits and shifts in and out LSB first: bits 31:0 hold data, bits 38:32 the address and bit 39 the direction flag. A captured frame carries the held result in bits 31:0 and zeros in bits 39:32.
- R2: A flag of 1 requests a write and 0 requests a read. After a write scan, the data field of the next frame is zero.
- R3: The result of the read requested in one scan is shifted out in the data field of the following scan. The first scan after reset shifts out zero.
- R4: A read of address 0 returns the ID_VALUE parameter. Address 1 returns 2**PTR_W. Address 2 returns RAM_WIDTH. Address 3 returns `status_i` zero-extended.
- R5: A read of address 4 returns `ram_data_i` at `ram_addr_o` (the read pointer) and pulses `ram_rd_o` for one cycle. It then advances the read pointer by one, wrapping modulo 2**PTR_W, so repeated reads stream consecutive entries.
- R6: A read of any address other than 4 leaves the read pointer unchanged and does not pulse `ram_rd_o`.
- R7: Writes take the low bits of the data field. Address 5 sets the read pointer (PTR_W bits, on `ram_addr_o`). Address 6 sets the write pointer (PTR_W bits, on `wrptr_o`). Address 7 sets the trigger count (32 bits, on `trig_cnt_o`). Address 8 sets the control register (CTRL_W bits, on `ctrl_o`). Each of these reads back zero-extended.
- R8: Writes to addresses 0 to 3 are ignored. Their read values and all writable state stay unchanged.
- R9: Addresses 9 to 127 read as zero, and writes to them change no state.
- R10: After reset, the pointers, trigger count, control and held result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| capture_i | input | 1 | Load the held result into the shift register |
| shift_i | input | 1 | Shift one bit, taking `tdi_i` in at bit 39 |
| update_i | input | 1 | Latch the frame and perform the access |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (bit 0 of the shift register) |
| status_i | input | STATUS_W | Live status bits returned at address 3 |
| ram_data_i | input | 32 | Trace RAM word at `ram_addr_o` |
| ram_addr_o | output | PTR_W | Read pointer into the trace RAM |
| ram_rd_o | output | 1 | One-cycle pulse when a RAM word is consumed |
| wrptr_o | output | PTR_W | Write pointer register |
| trig_cnt_o | output | 32 | Trigger count register |
| ctrl_o | output | CTRL_W | Control register |

## Verification
The assertions check the local cycle rules on every cycle. These are the one-bit shift step and the capture load, the pointer advance after a RAM read, the pointer holding on other reads, and the writable state holding on writes to read-only or unmapped addresses. Only the bench scenarios can show the rules that span scans. These are the one-scan delay between a request and its data, the read pointer wrapping while a stream of reads is in progress, and a closing read of address 0 leaving the pointer where the stream stopped. They also cover the values that each address returns across the whole map.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int FRAME_W = DATA_W + ADDR_W + 1;
    localparam int NREG    = 9;

    // Address order is the host-visible map.
    typedef enum logic [ADDR_W-1:0] {
        A_IDENT   = 7'd0,
        A_DEPTH   = 7'd1,
        A_WIDTH   = 7'd2,
        A_STATUS  = 7'd3,
        A_RAMDATA = 7'd4,
        A_RDPTR   = 7'd5,
        A_WRPTR   = 7'd6,
        A_TRIG    = 7'd7,
        A_CTRL    = 7'd8
    } reg_addr_e;

    // Packed MSB first: flag in bit 39, address 38:32, data 31:0.
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    localparam logic [NREG-1:0] WRITABLE_MASK = NREG'(9'b1_1110_0000);

endpackage

// File: rtl/sap_frame_shift.sv
module sap_frame_shift
    import sap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              update_i,
    input  logic              tdi_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              tdo_o,
    output frame_t            frame_o,
    output logic              upd_o
);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (update_i) begin
            st_d = st_q;
        end else if (capture_i) begin
            st_d.sr = {{(FRAME_W-DATA_W){1'b0}}, rd_data_i};
        end else if (shift_i) begin
            st_d.sr = {tdi_i, st_q.sr[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tdo_o   = st_q.sr[0];
    assign frame_o = frame_t'(st_q.sr);
    assign upd_o   = update_i;

    // R1
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !capture_i && !update_i) |=>
            (st_q.sr[FRAME_W-2:0] == $past(st_q.sr[FRAME_W-1:1]))
            && (st_q.sr[FRAME_W-1] == $past(tdi_i)));

    // R3
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && !update_i) |=>
            (st_q.sr == {{(FRAME_W-DATA_W){1'b0}}, $past(rd_data_i)}));

endmodule

// File: rtl/sap_addr_decode.sv
module sap_addr_decode
    import sap_pkg::*;
(
    input  logic              upd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NREG-1:0]   sel_o,
    output logic              rd_stb_o,
    output logic              wr_stb_o,
    output logic              ram_rd_o
);

    always_comb begin
        sel_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr_i == ADDR_W'(i)) sel_o[i] = 1'b1;
        end
    end

    assign rd_stb_o = upd_i && !wr_i;
    assign wr_stb_o = upd_i && wr_i && (|(sel_o & WRITABLE_MASK));
    assign ram_rd_o = rd_stb_o && sel_o[A_RAMDATA];

endmodule

// File: rtl/sap_reg_bank.sv
module sap_reg_bank
    import sap_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE  = 32'h1B9C_0A01,
    parameter int                PTR_W     = 4,
    parameter int                RAM_WIDTH = 32,
    parameter int                CTRL_W    = 2,
    parameter int                STATUS_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_i,
    input  logic [NREG-1:0]      sel_i,
    input  logic                 rd_stb_i,
    input  logic                 wr_stb_i,
    input  logic                 ram_rd_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_flag_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [STATUS_W-1:0]  status_i,
    input  logic [DATA_W-1:0]    ram_data_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic [PTR_W-1:0]     rdptr_o,
    output logic [PTR_W-1:0]     wrptr_o,
    output logic [DATA_W-1:0]    trig_o,
    output logic [CTRL_W-1:0]    ctrl_o
);

    localparam int DEPTH = 1 << PTR_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic [PTR_W-1:0]  rdptr;
        logic [PTR_W-1:0]  wrptr;
        logic [DATA_W-1:0] trig;
        logic [CTRL_W-1:0] ctrl;
    } bank_state_t;

    bank_state_t bk_d, bk_q;
    logic [DATA_W-1:0] regval [NREG];
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        for (int i = 0; i < NREG; i++) regval[i] = '0;
        regval[A_IDENT]   = ID_VALUE;
        regval[A_DEPTH]   = DATA_W'(DEPTH);
        regval[A_WIDTH]   = DATA_W'(RAM_WIDTH);
        regval[A_STATUS]  = DATA_W'(status_i);
        regval[A_RAMDATA] = ram_data_i;
        regval[A_RDPTR]   = DATA_W'(bk_q.rdptr);
        regval[A_WRPTR]   = DATA_W'(bk_q.wrptr);
        regval[A_TRIG]    = bk_q.trig;
        regval[A_CTRL]    = DATA_W'(bk_q.ctrl);
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel_i[i]) rd_mux = rd_mux | regval[i];
        end
    end

    always_comb begin
        bk_d = bk_q;
        if (acc_i) bk_d.rdata = rd_stb_i ? rd_mux : '0;
        if (ram_rd_i) bk_d.rdptr = bk_q.rdptr + 1'b1;
        if (wr_stb_i) begin
            if (sel_i[A_RDPTR]) bk_d.rdptr = wdata_i[PTR_W-1:0];
            if (sel_i[A_WRPTR]) bk_d.wrptr = wdata_i[PTR_W-1:0];
            if (sel_i[A_TRIG])  bk_d.trig  = wdata_i;
            if (sel_i[A_CTRL])  bk_d.ctrl  = wdata_i[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign rd_data_o = bk_q.rdata;
    assign rdptr_o   = bk_q.rdptr;
    assign wrptr_o   = bk_q.wrptr;
    assign trig_o    = bk_q.trig;
    assign ctrl_o    = bk_q.ctrl;

    // R5
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_i |=> (bk_q.rdptr == PTR_W'($past(bk_q.rdptr) + 1'b1)));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !wr_flag_i && addr_i != A_RAMDATA) |=> $stable(bk_q.rdptr));

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && wr_flag_i && addr_i == A_CTRL) |=>
            (bk_q.ctrl == $past(wdata_i[CTRL_W-1:0])));

    // R8
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && wr_flag_i && addr_i <= A_STATUS) |=>
            ($stable(bk_q.rdptr) && $stable(bk_q.wrptr)
             && $stable(bk_q.trig) && $stable(bk_q.ctrl)));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && wr_flag_i && addr_i > A_CTRL) |=>
            ($stable(bk_q.rdptr) && $stable(bk_q.wrptr)
             && $stable(bk_q.trig) && $stable(bk_q.ctrl)));

endmodule

// File: rtl/sap_scan_port.sv
module sap_scan_port
    import sap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE  = 32'h1B9C_0A01,
    parameter int          PTR_W     = 4,
    parameter int          RAM_WIDTH = 32,
    parameter int          CTRL_W    = 2,
    parameter int          STATUS_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture_i,
    input  logic                shift_i,
    input  logic                update_i,
    input  logic                tdi_i,
    output logic                tdo_o,
    input  logic [STATUS_W-1:0] status_i,
    input  logic [31:0]         ram_data_i,
    output logic [PTR_W-1:0]    ram_addr_o,
    output logic                ram_rd_o,
    output logic [PTR_W-1:0]    wrptr_o,
    output logic [31:0]         trig_cnt_o,
    output logic [CTRL_W-1:0]   ctrl_o
);

    frame_t            frame;
    logic              upd;
    logic [NREG-1:0]   sel;
    logic              rd_stb;
    logic              wr_stb;
    logic              ram_rd;
    logic [DATA_W-1:0] rd_data;

    sap_frame_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture_i),
        .shift_i   (shift_i),
        .update_i  (update_i),
        .tdi_i     (tdi_i),
        .rd_data_i (rd_data),
        .tdo_o     (tdo_o),
        .frame_o   (frame),
        .upd_o     (upd)
    );

    sap_addr_decode u_dec (
        .upd_i    (upd),
        .wr_i     (frame.wr),
        .addr_i   (frame.addr),
        .sel_o    (sel),
        .rd_stb_o (rd_stb),
        .wr_stb_o (wr_stb),
        .ram_rd_o (ram_rd)
    );

    sap_reg_bank #(
        .ID_VALUE  (ID_VALUE),
        .PTR_W     (PTR_W),
        .RAM_WIDTH (RAM_WIDTH),
        .CTRL_W    (CTRL_W),
        .STATUS_W  (STATUS_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_i      (upd),
        .sel_i      (sel),
        .rd_stb_i   (rd_stb),
        .wr_stb_i   (wr_stb),
        .ram_rd_i   (ram_rd),
        .addr_i     (frame.addr),
        .wr_flag_i  (frame.wr),
        .wdata_i    (frame.data),
        .status_i   (status_i),
        .ram_data_i (ram_data_i),
        .rd_data_o  (rd_data),
        .rdptr_o    (ram_addr_o),
        .wrptr_o    (wrptr_o),
        .trig_o     (trig_cnt_o),
        .ctrl_o     (ctrl_o)
    );

    assign ram_rd_o = ram_rd;

endmodule

// File: tb/sap_scan_port_bench.sv
module sap_scan_port_bench;

    localparam logic [31:0] ID  = 32'h1B9C_0A01;
    localparam logic [3:0]  STS = 4'b1010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic [31:0] ram_data;
    logic [3:0]  ram_addr, wrptr;
    logic        ram_rd;
    logic [31:0] trig;
    logic [1:0]  ctrl;

    int vectors = 0, miscompares = 0, ram_pulses = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [3:0]  m_rd = '0, m_wr = '0;
    logic [31:0] m_trig = '0;
    logic [1:0]  m_ctrl = '0;
    int          m_pulses = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] ram_word(input logic [3:0] a);
        return 32'hC0DE_0000 | (32'(a) * 32'h111);
    endfunction
    assign ram_data = ram_word(ram_addr);

    always @(posedge clk) if (ram_rd) ram_pulses++;

    sap_scan_port u_sap_scan_port (
        .clk(clk), .rst_n(rst_n), .capture_i(capture), .shift_i(shift),
        .update_i(update), .tdi_i(tdi), .tdo_o(tdo), .status_i(STS),
        .ram_data_i(ram_data), .ram_addr_o(ram_addr), .ram_rd_o(ram_rd),
        .wrptr_o(wrptr), .trig_cnt_o(trig), .ctrl_o(ctrl)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        check({req, " rdptr"}, 32'(ram_addr), 32'(m_rd));
        check({req, " wrptr"}, 32'(wrptr), 32'(m_wr));
        check({req, " trig"},  trig, m_trig);
        check({req, " ctrl"},  32'(ctrl), 32'(m_ctrl));
        check("R5 ram pulses", 32'(ram_pulses), 32'(m_pulses));
    endtask

    // Driver: model the access, push the result expected in the next frame.
    task automatic drive_model(input logic wr, input int addr, input logic [31:0] d, input string tag);
        logic [31:0] e;
        e = '0;
        if (wr) begin
            case (addr)
                5: m_rd   = d[3:0];
                6: m_wr   = d[3:0];
                7: m_trig = d;
                8: m_ctrl = d[1:0];
                default: ;
            endcase
        end else begin
            case (addr)
                0: e = ID;
                1: e = 32'd16;
                2: e = 32'd32;
                3: e = 32'(STS);
                4: begin e = ram_word(m_rd); m_rd = m_rd + 1'b1; m_pulses++; end
                5: e = 32'(m_rd);
                6: e = 32'(m_wr);
                7: e = m_trig;
                8: e = 32'(m_ctrl);
                default: e = '0;
            endcase
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic scan(input logic wr, input int addr, input logic [31:0] d, input string tag);
        logic [39:0] fin, fout;
        string t;
        logic [31:0] e;
        fin = {wr, 7'(addr), d};
        @(negedge clk) capture = 1'b1;
        @(negedge clk) capture = 1'b0;
        for (int i = 0; i < 40; i++) begin
            fout[i] = tdo;
            tdi = fin[i];
            shift = 1'b1;
            @(negedge clk);
        end
        shift = 1'b0;
        update = 1'b1;
        @(negedge clk) update = 1'b0;
        // Monitor: pop the item the previous scan pushed and compare.
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, fout[31:0], e);
        check("R1 upper frame bits", 32'(fout[39:32]), 32'd0);
        drive_model(wr, addr, d, tag);
        check_outs(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        exp_q.push_back('0);
        tag_q.push_back("R3 first frame after reset");
        repeat (3) @(negedge clk);
        check_outs("R10");
        check("R10 tdo", 32'(tdo), 0);
        rst_n = 1'b1;
        scan(0, 0, 32'hFFFF_FFFF, "R4 ident");
        scan(0, 1, 32'h0, "R4 depth");
        scan(0, 2, 32'h0, "R4 width");
        scan(0, 3, 32'h0, "R4 status");
        scan(0, 5, 32'h0, "R6 rdptr after reset");
        scan(1, 5, 32'hABCD_000E, "R2 write gives zero");
        scan(0, 4, 32'h0, "R5 stream 14");
        scan(0, 4, 32'h0, "R5 stream 15");
        scan(0, 4, 32'h0, "R5 stream wrap 0");
        scan(0, 0, 32'h0, "R6 closing ident read");
        scan(0, 5, 32'h0, "R6 rdptr after stream");
        scan(1, 8, 32'hFFFF_FFFF, "R7 ctrl write");
        scan(1, 7, 32'h1234_5678, "R7 trig write");
        scan(1, 6, 32'hFFFF_FFF5, "R7 wrptr write");
        scan(0, 8, 32'h0, "R7 ctrl readback");
        scan(0, 7, 32'h0, "R7 trig readback");
        scan(0, 6, 32'h0, "R7 wrptr readback");
        scan(1, 0, 32'hDEAD_BEEF, "R8 ident write");
        scan(1, 3, 32'hDEAD_BEEF, "R8 status write");
        scan(1, 1, 32'h0000_0001, "R8 depth write");
        scan(0, 0, 32'h0, "R8 ident after write");
        scan(0, 1, 32'h0, "R8 depth after write");
        scan(1, 100, 32'h5555_5555, "R9 unmapped write");
        scan(0, 100, 32'h0, "R9 read 100");
        scan(0, 127, 32'h0, "R9 read 127");
        scan(0, 9, 32'h0, "R9 read 9");
        scan(0, 4, 32'h0, "R5 stream 1");
        scan(1, 8, 32'h0000_0001, "R2 write after read");
        scan(0, 0, 32'h0, "R3 flush");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule